// File: doc/BRIEF.md
# Snoop-Gated DRAM Read Buffer

This block sits at the front of a memory controller and decides, per read, whether DRAM is read right away or only after the broadcast snoop has resolved. Each incoming read carries a one-bit hint from the requesting cache. A read hinted "speculate" goes straight to the DRAM command queue, so its DRAM access overlaps the snoop. A read hinted "hold" is parked in a small buffer until the snoop response with its transaction ID arrives. The parked read is then either dropped, because another cache will supply the line, or released to the DRAM command queue.

When a speculative read turns out to be served by another cache, its DRAM data is unused. The block marks that ID and swallows the data when it comes back from DRAM, so the requester never sees it. Four counters report speculative reads issued, speculative reads wasted, held reads dropped and held reads released. Released and speculative reads share one output queue with a valid/ready handshake. The block accepts a request only when the queue can absorb every parked read plus the new one, so a release never has to wait for space.

Top module: `spec_read_gate`

## Requirements
- R1: After reset, dq_valid and rsp_valid are 0, all four counters read 0 and req_ready is 1.
- R2: A read accepted with req_hold=0 (speculate) appears on the dq port in the cycle after acceptance at the earliest. Reads leave the queue in acceptance order, and cnt_spec rises by one for each.
- R3: A read accepted with req_hold=1 while the buffer has a free slot never reaches dq before its snoop response. A snoop response with snp_hit=1 for that ID discards it for good and raises cnt_drop by one.
- R4: A snoop response with snp_hit=0 for a parked ID puts that read into the output queue in the following cycle and raises cnt_rel by one. When a speculative read and a release enter in the same cycle, the speculative read is queued first.
- R5: When all HOLD_DEPTH slots are occupied, a read with req_hold=1 is treated as speculate: it is queued at once and counted in cnt_spec.
- R6: A snoop response with snp_hit=1 for an ID issued speculatively and not yet snooped raises cnt_waste by one. If that read's DRAM data has not yet returned and is not returning in the same cycle, the data is not forwarded: rsp_valid stays 0 when it arrives.
- R7: DRAM data whose ID is not marked discarded is forwarded combinationally: rsp_valid, rsp_id and rsp_data follow dram_valid, dram_id and dram_data in the same cycle.
- R8: A snoop response whose ID is neither parked nor an unsnooped speculative read changes no counter, no queue content and no buffer occupancy.
- R9: req_ready is 1 exactly when the queued entries plus the parked entries number fewer than OQ_DEPTH.
- R10: While dq_valid=1 and dq_ready=0, dq_valid, dq_id and dq_addr hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_id | input | ID_W | Transaction ID of the request |
| req_addr | input | ADDR_W | Read address |
| req_hold | input | 1 | Hint: 1 = wait for snoop, 0 = read DRAM now |
| snp_valid | input | 1 | Snoop response pulse |
| snp_id | input | ID_W | Transaction ID of the snoop response |
| snp_hit | input | 1 | 1 = another cache supplies the data |
| dq_valid | output | 1 | DRAM command queue entry available |
| dq_ready | input | 1 | DRAM scheduler takes the entry |
| dq_id | output | ID_W | Transaction ID of the queued read |
| dq_addr | output | ADDR_W | Address of the queued read |
| dram_valid | input | 1 | Read data returning from DRAM |
| dram_id | input | ID_W | Transaction ID of the returning data |
| dram_data | input | DATA_W | Returning read data |
| rsp_valid | output | 1 | Read data forwarded to the requester |
| rsp_id | output | ID_W | Transaction ID of forwarded data |
| rsp_data | output | DATA_W | Forwarded read data |
| cnt_spec | output | CNT_W | Speculative reads issued |
| cnt_waste | output | CNT_W | Speculative reads whose data went unused |
| cnt_drop | output | CNT_W | Held reads dropped on snoop hit |
| cnt_rel | output | CNT_W | Held reads released on snoop miss |

## Verification
A parked entry left over after its snoop shows up as occupancy that never drains. req_ready then drops early, and the next release or drop for that ID lands on the wrong slot within a few cycles. A wrong discard mark shows in the same cycle the matching DRAM data returns, as rsp_valid asserting or staying low against expectation. Queue pointer or ordering faults show one cycle after the push, because dq_id and dq_addr are compared against an ordered reference queue on every cycle under random back-pressure.

// File: rtl/srg_pkg.sv
package srg_pkg;

  // One flag per statistics event; field order sets the counter index.
  typedef struct packed {
    logic spec_issued;
    logic spec_wasted;
    logic held_dropped;
    logic held_released;
  } srg_evt_t;

  localparam int unsigned EVT_N = 4;

endpackage

// File: rtl/srg_hold_buf.sv
module srg_hold_buf #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [ID_W-1:0]   alloc_id,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              look_en,
  input  logic [ID_W-1:0]   look_id,
  output logic              look_hit,
  output logic [ADDR_W-1:0] look_addr,
  output logic              full,
  output logic [CW-1:0]     held_cnt
);

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] free_pick;
  logic [DEPTH-1:0] match_vec;
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];

  // lowest free slot wins the allocation
  always_comb begin
    logic found;
    free_pick = '0;
    found     = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        free_pick[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic load_en;
    assign match_vec[i] = vld_q[i] && (id_q[i] == look_id);
    assign load_en      = alloc_en && free_pick[i];
    always_ff @(posedge clk) begin
      if (load_en) begin
        id_q[i]   <= alloc_id;
        addr_q[i] <= alloc_addr;
      end
    end
  end

  always_comb begin
    look_addr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_vec[i]) look_addr = look_addr | addr_q[i];
    end
  end

  always_comb begin
    held_cnt = '0;
    for (int i = 0; i < DEPTH; i++) held_cnt = held_cnt + CW'(vld_q[i]);
  end

  assign look_hit = |match_vec;
  assign full     = &vld_q;

  always_comb begin
    vld_d = vld_q;
    if (look_en)  vld_d = vld_d & ~match_vec;
    if (alloc_en) vld_d = vld_d | free_pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

endmodule

// File: rtl/srg_out_fifo.sv
module srg_out_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 16,          // power of two
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_a,      // first in same-cycle order
  input  logic [W-1:0]  data_a,
  input  logic          push_b,
  input  logic [W-1:0]  data_b,
  input  logic          pop,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr0_en, wr1_en;
  logic [W-1:0]  wr0_data;

  assign wr0_en   = push_a | push_b;
  assign wr1_en   = push_a & push_b;
  assign wr0_data = push_a ? data_a : data_b;

  always_ff @(posedge clk) begin
    if (wr0_en) mem[wp_q] <= wr0_data;
    if (wr1_en) mem[wp_q + PW'(1)] <= data_b;
  end

  always_comb begin
    wp_d  = wp_q + PW'(wr0_en) + PW'(wr1_en);
    rp_d  = rp_q + PW'(pop);
    cnt_d = cnt_q + CW'(push_a) + CW'(push_b) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rp_q];
  assign count     = cnt_q;

endmodule

// File: rtl/srg_spec_track.sv
module srg_spec_track #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 64,
  localparam int NID   = 1 << ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_en,
  input  logic [ID_W-1:0]   issue_id,
  input  logic              snp_valid,
  input  logic [ID_W-1:0]   snp_id,
  input  logic              snp_hit,
  input  logic              dram_valid,
  input  logic [ID_W-1:0]   dram_id,
  input  logic [DATA_W-1:0] dram_data,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wasted
);

  // live: issued, not yet snooped; pend: data not back; disc: drop data
  logic [NID-1:0] live_q, live_d, pend_q, pend_d, disc_q, disc_d;

  always_comb begin
    live_d = live_q;
    pend_d = pend_q;
    disc_d = disc_q;
    wasted = 1'b0;
    if (dram_valid) begin
      pend_d[dram_id] = 1'b0;
      disc_d[dram_id] = 1'b0;
    end
    if (snp_valid && live_q[snp_id]) begin
      live_d[snp_id] = 1'b0;
      if (snp_hit) begin
        wasted = 1'b1;
        if (pend_q[snp_id] && !(dram_valid && dram_id == snp_id))
          disc_d[snp_id] = 1'b1;
      end
    end
    if (issue_en) begin
      live_d[issue_id] = 1'b1;
      pend_d[issue_id] = 1'b1;
      disc_d[issue_id] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      pend_q <= '0;
      disc_q <= '0;
    end else begin
      live_q <= live_d;
      pend_q <= pend_d;
      disc_q <= disc_d;
    end
  end

  assign rsp_valid = dram_valid && !disc_q[dram_id];
  assign rsp_id    = dram_id;
  assign rsp_data  = dram_data;

endmodule

// File: rtl/srg_evt_cnt.sv
module srg_evt_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] value
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign value = cnt_q;

endmodule

// File: rtl/spec_read_gate.sv
module spec_read_gate
  import srg_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int HOLD_DEPTH = 8,
  parameter int OQ_DEPTH   = 16,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_hold,
  input  logic              snp_valid,
  input  logic [ID_W-1:0]   snp_id,
  input  logic              snp_hit,
  output logic              dq_valid,
  input  logic              dq_ready,
  output logic [ID_W-1:0]   dq_id,
  output logic [ADDR_W-1:0] dq_addr,
  input  logic              dram_valid,
  input  logic [ID_W-1:0]   dram_id,
  input  logic [DATA_W-1:0] dram_data,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CNT_W-1:0]  cnt_spec,
  output logic [CNT_W-1:0]  cnt_waste,
  output logic [CNT_W-1:0]  cnt_drop,
  output logic [CNT_W-1:0]  cnt_rel
);

  localparam int OQ_W = ID_W + ADDR_W;
  localparam int HCW  = $clog2(HOLD_DEPTH + 1);
  localparam int QCW  = $clog2(OQ_DEPTH) + 1;
  localparam int OCW  = ((HCW > QCW) ? HCW : QCW) + 1;

  logic              buf_full, look_hit;
  logic [ADDR_W-1:0] look_addr;
  logic [HCW-1:0]    held_cnt;
  logic [QCW-1:0]    fifo_cnt;
  logic [OCW-1:0]    occupancy;
  logic              accept, to_hold, to_spec, snp_drop, snp_rel, wasted, pop;
  logic [OQ_W-1:0]   dq_word;
  srg_evt_t          evt;
  logic [EVT_N-1:0]  evt_bits;
  logic [EVT_N-1:0][CNT_W-1:0] cnt_all;

  // every parked read keeps one queue slot reserved for its release
  assign occupancy = OCW'(fifo_cnt) + OCW'(held_cnt);
  assign req_ready = occupancy < OCW'(OQ_DEPTH);
  assign accept    = req_valid && req_ready;
  assign to_hold   = accept && req_hold && !buf_full;
  assign to_spec   = accept && !to_hold;
  assign snp_drop  = snp_valid && look_hit && snp_hit;
  assign snp_rel   = snp_valid && look_hit && !snp_hit;
  assign pop       = dq_valid && dq_ready;

  srg_hold_buf #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DEPTH(HOLD_DEPTH)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (to_hold),
    .alloc_id  (req_id),
    .alloc_addr(req_addr),
    .look_en   (snp_valid),
    .look_id   (snp_id),
    .look_hit  (look_hit),
    .look_addr (look_addr),
    .full      (buf_full),
    .held_cnt  (held_cnt)
  );

  srg_out_fifo #(.W(OQ_W), .DEPTH(OQ_DEPTH)) u_oq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_a   (to_spec),
    .data_a   ({req_id, req_addr}),
    .push_b   (snp_rel),
    .data_b   ({snp_id, look_addr}),
    .pop      (pop),
    .out_valid(dq_valid),
    .out_data (dq_word),
    .count    (fifo_cnt)
  );

  assign dq_id   = dq_word[OQ_W-1:ADDR_W];
  assign dq_addr = dq_word[ADDR_W-1:0];

  srg_spec_track #(.ID_W(ID_W), .DATA_W(DATA_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_en  (to_spec),
    .issue_id  (req_id),
    .snp_valid (snp_valid),
    .snp_id    (snp_id),
    .snp_hit   (snp_hit),
    .dram_valid(dram_valid),
    .dram_id   (dram_id),
    .dram_data (dram_data),
    .rsp_valid (rsp_valid),
    .rsp_id    (rsp_id),
    .rsp_data  (rsp_data),
    .wasted    (wasted)
  );

  always_comb begin
    evt.spec_issued   = to_spec;
    evt.spec_wasted   = wasted;
    evt.held_dropped  = snp_drop;
    evt.held_released = snp_rel;
  end
  assign evt_bits = evt;

  for (genvar k = 0; k < EVT_N; k++) begin : g_cnt
    srg_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (evt_bits[k]),
      .value(cnt_all[k])
    );
  end

  assign cnt_spec  = cnt_all[3];
  assign cnt_waste = cnt_all[2];
  assign cnt_drop  = cnt_all[1];
  assign cnt_rel   = cnt_all[0];

endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
  parameter int ID_W     = 4,
  parameter int ADDR_W   = 32,
  parameter int OQ_DEPTH = 16,
  parameter int CNT_W    = 16,
  parameter int HCW      = 4,
  parameter int QCW      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              snp_valid,
  input logic              snp_hit,
  input logic              dq_valid,
  input logic              dq_ready,
  input logic [ID_W-1:0]   dq_id,
  input logic [ADDR_W-1:0] dq_addr,
  input logic [HCW-1:0]    held_cnt,
  input logic [QCW-1:0]    fifo_cnt,
  input logic [CNT_W-1:0]  cnt_spec,
  input logic [CNT_W-1:0]  cnt_waste,
  input logic [CNT_W-1:0]  cnt_drop,
  input logic [CNT_W-1:0]  cnt_rel
);

  assert_dq_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid && !dq_ready |=> dq_valid && $stable(dq_id) && $stable(dq_addr));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fifo_cnt) + int'(held_cnt)) <= OQ_DEPTH);

  assert_spec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_spec != $past(cnt_spec) |->
      $past(req_valid && req_ready) && cnt_spec == CNT_W'($past(cnt_spec) + 1'b1));

  assert_drop_only_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_drop != $past(cnt_drop) |->
      $past(snp_valid && snp_hit) && cnt_rel == $past(cnt_rel));

  assert_release_queued_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rel != $past(cnt_rel) |-> $past(snp_valid && !snp_hit) && dq_valid);

  assert_waste_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_waste != $past(cnt_waste) |->
      $past(snp_valid && snp_hit) && cnt_waste == CNT_W'($past(cnt_waste) + 1'b1));

endmodule

bind spec_read_gate srg_checker #(
  .ID_W(ID_W), .ADDR_W(ADDR_W), .OQ_DEPTH(OQ_DEPTH), .CNT_W(CNT_W),
  .HCW($clog2(HOLD_DEPTH + 1)), .QCW($clog2(OQ_DEPTH) + 1)
) u_srg_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .snp_valid(snp_valid), .snp_hit(snp_hit), .dq_valid(dq_valid),
  .dq_ready(dq_ready), .dq_id(dq_id), .dq_addr(dq_addr),
  .held_cnt(held_cnt), .fifo_cnt(fifo_cnt), .cnt_spec(cnt_spec),
  .cnt_waste(cnt_waste), .cnt_drop(cnt_drop), .cnt_rel(cnt_rel)
);

// File: tb/test_spec_read_gate.sv
module test_spec_read_gate;
  localparam int ID_W = 4, ADDR_W = 32, DATA_W = 64;
  localparam int HOLD = 8, OQD = 16, CNT_W = 16, NID = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic              rst_n;
  logic              req_valid, req_ready, req_hold;
  logic [ID_W-1:0]   req_id;
  logic [ADDR_W-1:0] req_addr;
  logic              snp_valid, snp_hit;
  logic [ID_W-1:0]   snp_id;
  logic              dq_valid, dq_ready;
  logic [ID_W-1:0]   dq_id;
  logic [ADDR_W-1:0] dq_addr;
  logic              dram_valid;
  logic [ID_W-1:0]   dram_id;
  logic [DATA_W-1:0] dram_data;
  logic              rsp_valid;
  logic [ID_W-1:0]   rsp_id;
  logic [DATA_W-1:0] rsp_data;
  logic [CNT_W-1:0]  cnt_spec, cnt_waste, cnt_drop, cnt_rel;

  spec_read_gate #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .HOLD_DEPTH(HOLD), .OQ_DEPTH(OQD), .CNT_W(CNT_W)) i_spec_read_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_addr(req_addr), .req_hold(req_hold),
    .snp_valid(snp_valid), .snp_id(snp_id), .snp_hit(snp_hit),
    .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_id(dq_id), .dq_addr(dq_addr),
    .dram_valid(dram_valid), .dram_id(dram_id), .dram_data(dram_data),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .cnt_spec(cnt_spec), .cnt_waste(cnt_waste), .cnt_drop(cnt_drop), .cnt_rel(cnt_rel)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference state built from the requirements
  bit                m_held [NID];
  logic [ADDR_W-1:0] m_haddr[NID];
  bit                m_live [NID];
  bit                m_pend [NID];
  bit                m_disc [NID];
  logic [ID_W-1:0]   q_id[$];
  logic [ADDR_W-1:0] q_addr[$];
  int unsigned       m_cnt[4];   // 0 spec, 1 waste, 2 drop, 3 rel

  function automatic int held_count();
    int c = 0;
    for (int i = 0; i < NID; i++) if (m_held[i]) c++;
    return c;
  endfunction

  function automatic bit exp_ready();
    return (q_id.size() + held_count()) < OQD;
  endfunction

  function automatic bit busy(int id);
    if (m_held[id] || m_live[id] || m_pend[id] || m_disc[id]) return 1'b1;
    foreach (q_id[k]) if (int'(q_id[k]) == id) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    bit exp_rsp;
    chk("R9", "req_ready", 64'(req_ready), 64'(exp_ready()));
    chk("R2/R4/R10", "dq_valid", 64'(dq_valid), 64'(q_id.size() > 0));
    if (q_id.size() > 0) begin
      chk("R2/R4/R10", "dq_id", 64'(dq_id), 64'(q_id[0]));
      chk("R2/R4/R10", "dq_addr", 64'(dq_addr), 64'(q_addr[0]));
    end
    exp_rsp = dram_valid && !m_disc[dram_id];
    chk("R6/R7", "rsp_valid", 64'(rsp_valid), 64'(exp_rsp));
    if (exp_rsp) begin
      chk("R7", "rsp_data", rsp_data, dram_data);
      chk("R7", "rsp_id", 64'(rsp_id), 64'(dram_id));
    end
    chk("R2/R5", "cnt_spec", 64'(cnt_spec), 64'(m_cnt[0]));
    chk("R6", "cnt_waste", 64'(cnt_waste), 64'(m_cnt[1]));
    chk("R3", "cnt_drop", 64'(cnt_drop), 64'(m_cnt[2]));
    chk("R4", "cnt_rel", 64'(cnt_rel), 64'(m_cnt[3]));
  endtask

  task automatic model_update();
    bit acc, full_now, matched;
    acc      = req_valid && exp_ready();
    full_now = held_count() >= HOLD;
    matched  = snp_valid && m_held[snp_id];
    if (dq_valid && dq_ready && q_id.size() > 0) begin
      void'(q_id.pop_front());
      void'(q_addr.pop_front());
    end
    if (acc && req_hold && !full_now) begin
      m_held[req_id]  = 1'b1;
      m_haddr[req_id] = req_addr;
    end else if (acc) begin
      q_id.push_back(req_id);
      q_addr.push_back(req_addr);
      m_cnt[0]++;
    end
    if (matched) begin
      m_held[snp_id] = 1'b0;
      if (snp_hit) m_cnt[2]++;
      else begin
        m_cnt[3]++;
        q_id.push_back(snp_id);
        q_addr.push_back(m_haddr[snp_id]);
      end
    end else if (snp_valid && m_live[snp_id]) begin
      if (snp_hit) begin
        m_cnt[1]++;
        if (m_pend[snp_id] && !(dram_valid && dram_id == snp_id)) m_disc[snp_id] = 1'b1;
      end
      m_live[snp_id] = 1'b0;
    end
    if (dram_valid) begin
      m_pend[dram_id] = 1'b0;
      m_disc[dram_id] = 1'b0;
    end
    if (acc && !(req_hold && !full_now)) begin
      m_live[req_id] = 1'b1;
      m_pend[req_id] = 1'b1;
      m_disc[req_id] = 1'b0;
    end
  endtask

  task automatic idle();
    req_valid = 0; req_hold = 0; req_id = '0; req_addr = '0;
    snp_valid = 0; snp_hit = 0; snp_id = '0;
    dram_valid = 0; dram_id = '0; dram_data = '0;
  endtask

  // inputs are set at a falling edge; check, advance model, cross the rising edge
  task automatic step();
    #1;
    check_outputs();
    model_update();
    @(negedge clk);
    idle();
  endtask

  task automatic do_req(int id, bit hold, logic [ADDR_W-1:0] a);
    req_valid = 1; req_id = ID_W'(id); req_hold = hold; req_addr = a;
    step();
  endtask

  task automatic do_snp(int id, bit hit);
    snp_valid = 1; snp_id = ID_W'(id); snp_hit = hit;
    step();
  endtask

  task automatic do_dram(int id, logic [DATA_W-1:0] d);
    dram_valid = 1; dram_id = ID_W'(id); dram_data = d;
    step();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NID; i++) begin
      m_held[i] = 0; m_live[i] = 0; m_pend[i] = 0; m_disc[i] = 0; m_haddr[i] = '0;
    end
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    rst_n = 0; dq_ready = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "dq_valid", 64'(dq_valid), 64'd0);
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1", "req_ready", 64'(req_ready), 64'd1);
    chk("R1", "counters", {cnt_spec, cnt_waste, cnt_drop, cnt_rel}, 64'd0);
    @(negedge clk);

    // directed: one speculative read, then fill the hold buffer
    dq_ready = 0;
    do_req(1, 0, 32'h100);
    for (int i = 2; i <= 9; i++) do_req(i, 1, 32'h200 + 32'(i));
    do_req(10, 1, 32'h300);   // buffer full -> speculate
    chk("R5", "cnt_spec after full buffer", 64'(cnt_spec), 64'd2);
    chk("R3", "held read not issued", 64'(dq_id), 64'd1);

    // R8: unknown ID leaves everything alone
    do_snp(15, 1);
    chk("R8", "counters after unknown snoop", {cnt_waste, cnt_drop, cnt_rel}, 48'd0);
    chk("R8", "dq head after unknown snoop", 64'(dq_id), 64'd1);

    do_snp(3, 1);              // R3 drop
    do_snp(5, 0);              // R4 release
    do_snp(2, 0);
    chk("R3", "cnt_drop", 64'(cnt_drop), 64'd1);
    chk("R4", "cnt_rel", 64'(cnt_rel), 64'd2);

    // R6: speculative read 10 wasted, its data swallowed
    do_snp(10, 1);
    dram_valid = 1; dram_id = 4'd10; dram_data = 64'hDEAD_0010;
    #1;
    chk("R6", "discarded data rsp_valid", 64'(rsp_valid), 64'd0);
    step();
    chk("R6", "cnt_waste", 64'(cnt_waste), 64'd1);

    // R7: data back before snoop is delivered
    dram_valid = 1; dram_id = 4'd1; dram_data = 64'hBEEF_0001;
    #1;
    chk("R7", "early data rsp_valid", 64'(rsp_valid), 64'd1);
    step();
    do_snp(1, 0);

    // drain, order 1,10,5,2 checked by the reference queue
    dq_ready = 1;
    repeat (8) step();

    // constrained random phase
    for (int it = 0; it < 4000; it++) begin
      int rid;
      dq_ready = ($urandom % 4) != 0;
      rid = -1;
      if ($urandom % 2 == 0) begin
        for (int t = 0; t < 4; t++) begin
          int c = int'($urandom % NID);
          if (rid < 0 && !busy(c)) rid = c;
        end
        if (rid >= 0) begin
          req_valid = 1; req_id = ID_W'(rid);
          req_hold  = ($urandom % 5) < 3;
          req_addr  = $urandom;
        end
      end
      if ($urandom % 3 == 0) begin
        int s = int'($urandom % NID);
        if (s != rid) begin
          if (m_held[s] || m_live[s]) begin
            snp_valid = 1; snp_id = ID_W'(s); snp_hit = $urandom % 2;
          end else if (!busy(s) && ($urandom % 4 == 0)) begin
            snp_valid = 1; snp_id = ID_W'(s); snp_hit = $urandom % 2;  // R8 unknown ID
          end
        end
      end
      if ($urandom % 3 == 0) begin
        for (int t = 0; t < 4; t++) begin
          int d = int'($urandom % NID);
          if (!dram_valid && m_pend[d]) begin
            dram_valid = 1; dram_id = ID_W'(d); dram_data = {$urandom, $urandom};
          end
        end
      end
      step();
    end

    dq_ready = 1;
    repeat (40) step();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule